// File: doc/BRIEF.md
# PWM Generator with Shadowed Period and Width Reload

This block produces a pulse-width-modulated output from a free-running period counter that advances once per incoming prescaler tick. Software supplies a period count, a width count, a bit that selects the output level during the OFF phase, and a force-load strobe. Every period opens with the ON phase. The output stays ON while the counter is below the width and goes OFF for the rest of the period.

New period and width values are written into shadow registers. They reach the active counter and comparator only when the current period wraps, so a running waveform never sees a half-updated pair. A force-load strobe sets a self-clearing load flag. In the following cycle the flag copies the shadow pair into the active registers, restarts the counter at zero and then clears itself. The OFF-level bit is not shadowed and acts on the output at once. A one-cycle period-end pulse marks every wrap, so surrounding logic can count or align to period boundaries.

Top module: `pwm_shadow_gen`

## Requirements
- R1: The output drives the inverse of `off_level` while the active count is below the active width (ON phase). It drives `off_level` itself otherwise (OFF phase).
- R2: Every period, including the first period after a restart or after enable returns high, starts at count 0 and therefore in the ON phase whenever the width is nonzero.
- R3: A width of 0 holds the output at the OFF level for the whole period. A width equal to or larger than the period holds it at the ON level for the whole period.
- R4: The counter advances only in cycles with `tick` high. For a period value P≥2 it runs 0,1,…,P-1 and then wraps to 0, so one period lasts P ticks. With `tick` low the output and counter hold.
- R5: Period and width writes made without force-load go to shadow storage. They take effect exactly at the next wrap, and the rest of the current period keeps the old values.
- R6: One clock after a `force_load` strobe, the shadow period and width become active and the counter restarts at 0, whatever its position was.
- R7: `load_bit` reads 1 only in the cycle after a `force_load` strobe and reads 0 from the following cycle on.
- R8: `period_end` is high for exactly the one cycle after each tick that wraps the counter. A force-load restart does not raise it.
- R9: While `enable` is low, the counter is held at 0, the output sits at the OFF level and `period_end` stays low.
- R10: `off_level` is not shadowed. A change drives the output to the new level combinationally, without waiting for a period boundary.
- R11: After reset, shadow and active period and width hold the reset parameters (4 and 2 by default), `load_bit` and `period_end` are 0, and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; when low the counter holds at 0 and the output sits OFF |
| tick | input | 1 | Prescaler tick, one clock wide, advances the counter |
| per_wr | input | 1 | Write strobe for the shadow period |
| per_in | input | W | Period value to store in the shadow |
| wid_wr | input | 1 | Write strobe for the shadow width |
| wid_in | input | W | Width value to store in the shadow |
| off_level | input | 1 | Output level during the OFF phase (unshadowed) |
| force_load | input | 1 | Strobe that requests an immediate reload and restart |
| pwm_out | output | 1 | PWM output |
| period_end | output | 1 | One-cycle pulse after each counter wrap |
| load_bit | output | 1 | Readback of the self-clearing load flag |

## Verification
The bench builds the block with its default 16-bit counter and the reset values period 4 and width 2. These values let it check the waveform straight out of reset before anything has been written. Periods of 4 to 10 ticks keep each wrap, shadow hand-over and forced restart within a few dozen cycles, so a single run covers both ends of the width range, both polarities and a shadow write made in the middle of a period. Holding `tick` low, dropping `enable`, and flipping `off_level` during a period reach the hold and unshadowed-polarity paths.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Phase of the PWM waveform inside one period.
    typedef enum logic {
        PH_OFF = 1'b0,
        PH_ON  = 1'b1
    } pwm_phase_e;

    // Map a phase to a pin level given the OFF-phase level.
    function automatic logic phase_level(pwm_phase_e ph, logic off_lvl);
        return (ph == PH_ON) ? ~off_lvl : off_lvl;
    endfunction

endpackage

// File: rtl/pwm_shadow_bank.sv
// Shadow and active copies of period and width, plus the self-clearing
// load flag that forces an immediate transfer.
module pwm_shadow_bank #(
    parameter int unsigned W       = 16,
    parameter int unsigned PER_RST = 4,
    parameter int unsigned WID_RST = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         per_wr,
    input  logic [W-1:0] per_in,
    input  logic         wid_wr,
    input  logic [W-1:0] wid_in,
    input  logic         force_load,
    input  logic         wrap,
    output logic [W-1:0] act_per,
    output logic [W-1:0] act_wid,
    output logic         load_pend
);

    localparam logic [W-1:0] PER_INIT = W'(PER_RST);
    localparam logic [W-1:0] WID_INIT = W'(WID_RST);

    typedef struct packed {
        logic [W-1:0] shd_per;
        logic [W-1:0] shd_wid;
        logic [W-1:0] act_per;
        logic [W-1:0] act_wid;
        logic         load;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (per_wr) begin
            st_d.shd_per = per_in;
        end
        if (wid_wr) begin
            st_d.shd_wid = wid_in;
        end
        // The flag lives for one cycle, then clears itself.
        st_d.load = force_load;
        // Transfer happens at a forced load or at a natural wrap.
        if (st_q.load || wrap) begin
            st_d.act_per = st_q.shd_per;
            st_d.act_wid = st_q.shd_wid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{shd_per: PER_INIT, shd_wid: WID_INIT,
                      act_per: PER_INIT, act_wid: WID_INIT, load: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign act_per   = st_q.act_per;
    assign act_wid   = st_q.act_wid;
    assign load_pend = st_q.load;

endmodule

// File: rtl/pwm_period_counter.sv
// Tick-driven period counter with wrap detection and a registered
// period-end pulse.
module pwm_period_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         tick,
    input  logic         restart,
    input  logic [W-1:0] act_per,
    output logic [W-1:0] cnt,
    output logic         wrap,
    output logic         period_end
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pend;
    } ctr_t;

    ctr_t         st_d, st_q;
    logic [W-1:0] last;
    logic         at_last;

    always_comb begin
        // Periods of 0 or 1 keep the counter parked at 0.
        last    = (act_per <= ONE) ? '0 : (act_per - ONE);
        at_last = (st_q.cnt >= last);
        wrap    = enable && tick && !restart && at_last;

        st_d      = st_q;
        st_d.pend = wrap;
        if (!enable) begin
            st_d.cnt = '0;
        end else if (restart) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = at_last ? '0 : (st_q.cnt + ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt        = st_q.cnt;
    assign period_end = st_q.pend;

endmodule

// File: rtl/pwm_level_stage.sv
// Compares the count against the width and applies the unshadowed
// OFF-level selection.
module pwm_level_stage
    import pwm_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         enable,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] act_wid,
    input  logic         off_level,
    output logic         pwm_out
);

    pwm_phase_e phase;

    always_comb begin
        phase   = (enable && (cnt < act_wid)) ? PH_ON : PH_OFF;
        pwm_out = phase_level(phase, off_level);
    end

endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen #(
    parameter int unsigned W       = 16,
    parameter int unsigned PER_RST = 4,
    parameter int unsigned WID_RST = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         tick,
    input  logic         per_wr,
    input  logic [W-1:0] per_in,
    input  logic         wid_wr,
    input  logic [W-1:0] wid_in,
    input  logic         off_level,
    input  logic         force_load,
    output logic         pwm_out,
    output logic         period_end,
    output logic         load_bit
);

    logic [W-1:0] act_per;
    logic [W-1:0] act_wid;
    logic [W-1:0] cnt;
    logic         wrap;
    logic         load_pend;

    pwm_shadow_bank #(
        .W       (W),
        .PER_RST (PER_RST),
        .WID_RST (WID_RST)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .per_wr     (per_wr),
        .per_in     (per_in),
        .wid_wr     (wid_wr),
        .wid_in     (wid_in),
        .force_load (force_load),
        .wrap       (wrap),
        .act_per    (act_per),
        .act_wid    (act_wid),
        .load_pend  (load_pend)
    );

    pwm_period_counter #(
        .W (W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tick       (tick),
        .restart    (load_pend),
        .act_per    (act_per),
        .cnt        (cnt),
        .wrap       (wrap),
        .period_end (period_end)
    );

    pwm_level_stage #(
        .W (W)
    ) u_lvl (
        .enable    (enable),
        .cnt       (cnt),
        .act_wid   (act_wid),
        .off_level (off_level),
        .pwm_out   (pwm_out)
    );

    assign load_bit = load_pend;

endmodule

// File: rtl/pwm_shadow_gen_chk.sv
module pwm_shadow_gen_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enable,
    input logic         off_level,
    input logic         force_load,
    input logic         pwm_out,
    input logic         period_end,
    input logic         load_bit,
    input logic [W-1:0] cnt,
    input logic [W-1:0] act_per,
    input logic [W-1:0] act_wid
);

    localparam logic [W-1:0] ONE = W'(1);

    // R7: flag clears itself unless a new strobe arrives
    p_load_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_bit && !force_load) |=> !load_bit);

    // R6: a pending load restarts the count at zero
    p_load_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_bit |=> (cnt == '0));

    // R5: active values move only at a wrap or a forced load
    p_active_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_per) || !$stable(act_wid)) |-> ($past(load_bit) || period_end));

    // R8: the boundary pulse lasts one cycle for periods above one tick
    p_pend_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && (act_per > ONE)) |=> !period_end);

    // R8: a wrap always leaves the counter at zero
    p_pend_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |-> (cnt == '0));

    // R9: disabled block holds the counter and raises no boundary pulse
    p_disabled_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ((cnt == '0) && !period_end));

    // R9: disabled output sits at the OFF level
    p_disabled_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (pwm_out == off_level));

    // R2: count 0 with a nonzero width is the ON phase
    p_start_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (cnt == '0) && (act_wid != '0)) |-> (pwm_out != off_level));

endmodule

bind pwm_shadow_gen pwm_shadow_gen_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .off_level  (off_level),
    .force_load (force_load),
    .pwm_out    (pwm_out),
    .period_end (period_end),
    .load_bit   (load_bit),
    .cnt        (cnt),
    .act_per    (act_per),
    .act_wid    (act_wid)
);

// File: tb/sim_pwm_shadow_gen.sv
module sim_pwm_shadow_gen;

    localparam int  W      = 16;
    localparam time CLK_PD = 10;
    localparam int  NVEC   = 5;

    // {off_level, period, width}
    localparam logic [2*W:0] VEC [NVEC] = '{
        {1'b0, 16'd8,  16'd3},
        {1'b1, 16'd5,  16'd0},   // R3: zero width
        {1'b0, 16'd4,  16'd6},   // R3: width above period
        {1'b1, 16'd10, 16'd9},
        {1'b1, 16'd6,  16'd6}    // R3: width equal to period
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         tick = 1'b0;
    logic         per_wr = 1'b0;
    logic [W-1:0] per_in = '0;
    logic         wid_wr = 1'b0;
    logic [W-1:0] wid_in = '0;
    logic         off_level = 1'b0;
    logic         force_load = 1'b0;
    logic         pwm_out;
    logic         period_end;
    logic         load_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PD/2) clk = ~clk;

    pwm_shadow_gen #(.W(W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tick       (tick),
        .per_wr     (per_wr),
        .per_in     (per_in),
        .wid_wr     (wid_wr),
        .wid_in     (wid_in),
        .off_level  (off_level),
        .force_load (force_load),
        .pwm_out    (pwm_out),
        .period_end (period_end),
        .load_bit   (load_bit)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_lvl(int k, int p, int wd, logic pol);
        return ((k % p) < wd) ? ~pol : pol;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Write shadow pair, strobe force-load, land at count 0 (R6, R7).
    task automatic load_now(input int p, input int wd, input logic pol);
        per_in = W'(p); wid_in = W'(wd); per_wr = 1'b1; wid_wr = 1'b1;
        off_level = pol; force_load = 1'b1;
        step();
        per_wr = 1'b0; wid_wr = 1'b0; force_load = 1'b0;
        chk("R7 load flag set", load_bit, 1'b1);
        step();
        chk("R7 load flag cleared", load_bit, 1'b0);
    endtask

    // Walk n cycles from count 0 checking level (R1) and wrap pulse (R8).
    task automatic run_pat(input int p, input int wd, input logic pol,
                           input int n, input bit wrapped_in);
        for (int k = 0; k < n; k++) begin
            chk("R1 level", pwm_out, exp_lvl(k, p, wd, pol));
            chk("R8 period end", period_end,
                ((k % p) == 0) && ((k > 0) || wrapped_in));
            step();
        end
    endtask

    initial begin
        #(CLK_PD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic held;
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11 reset load_bit", load_bit, 1'b0);
        chk("R11 reset period_end", period_end, 1'b0);
        chk("R9 reset output off", pwm_out, 1'b0);
        rst_n = 1'b1; enable = 1'b1; tick = 1'b1;
        #1;
        // R11: reset values 4/2 drive the waveform directly
        run_pat(4, 2, 1'b0, 8, 1'b0);

        // Vector table: R1, R3, R4, R6, R8
        for (int v = 0; v < NVEC; v++) begin
            load_now(int'(VEC[v][2*W-1:W]), int'(VEC[v][W-1:0]), VEC[v][2*W]);
            run_pat(int'(VEC[v][2*W-1:W]), int'(VEC[v][W-1:0]), VEC[v][2*W],
                    2 * int'(VEC[v][2*W-1:W]), 1'b0);
        end

        // R5: shadow write mid-period waits for the wrap
        load_now(8, 3, 1'b0);
        run_pat(8, 3, 1'b0, 3, 1'b0);
        per_in = 16'd6; wid_in = 16'd2; per_wr = 1'b1; wid_wr = 1'b1;
        for (int k = 3; k < 8; k++) begin
            chk("R5 old values kept", pwm_out, exp_lvl(k, 8, 3, 1'b0));
            step();
            per_wr = 1'b0; wid_wr = 1'b0;
        end
        run_pat(6, 2, 1'b0, 12, 1'b1);

        // R6: forced load mid-period restarts at 0 with the new pair
        step(); step(); step();
        load_now(5, 4, 1'b0);
        chk("R6 restart begins ON", pwm_out, 1'b1);
        run_pat(5, 4, 1'b0, 10, 1'b0);

        // R9: enable low holds OFF and no pulse
        step(); step();
        enable = 1'b0;
        #1;
        for (int k = 0; k < 4; k++) begin
            chk("R9 disabled off", pwm_out, 1'b0);
            step();
            chk("R9 disabled no pulse", period_end, 1'b0);
        end
        // R2: resumes at count 0 in the ON phase
        enable = 1'b1;
        #1;
        run_pat(5, 4, 1'b0, 10, 1'b0);

        // R4: tick low holds the waveform
        step(); step(); step(); step();
        tick = 1'b0;
        held = pwm_out;
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R4 hold without tick", pwm_out, held);
            chk("R4 no pulse without tick", period_end, 1'b0);
        end

        // R10: polarity acts immediately
        off_level = 1'b1;
        #1;
        chk("R10 polarity immediate", pwm_out, ~held);
        off_level = 1'b0;
        #1;
        chk("R10 polarity restored", pwm_out, held);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule